// File: doc/BRIEF.md
# Power Mode Controller with Wake-Up Latch

This block moves an embedded controller between a full-speed Active mode and a low-power Idle mode. Software arms Idle through an eight-bit control register on a simple write/read port, then the CPU core raises its WAIT request. The controller answers by gating the core clock, optionally stopping the high-frequency oscillator, and holding the core halted. If Idle is not armed, a WAIT only halts the core with all clocks left running.

The whole block runs from the always-on low-frequency clock (nominally 32.768 kHz). Three wake sources are accepted: a maskable event (active-high level), a non-maskable interrupt (falling edge) and a debug interrupt (falling edge, honoured only in development mode). Each passes a two-flop synchronizer before detection. A detected event sets a pending flag that holds until the core performs an interrupt-acknowledge cycle or reset is applied. A wake returns the chip straight to Active and clears the idle-request bit in hardware. If the oscillator was stopped, it is restarted first and the core clock stays gated until the oscillator reports itself stable.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After reset the block is Active: coreClkEn=1, hfOscEn=1, coreHalt=0, regRdData=0 and wakePending=0.
- R2: Control register fields are bit 1 (stop oscillator in Idle), bit 2 (idle request) and bit 5 (idle enable). They are written on any cycle with regWrEn=1. Bits 0, 3, 4, 6 and 7 always read as 0.
- R3: When waitReq is sampled high with bits 2 and 5 both set and no wake pending, Idle is entered from the next cycle: coreClkEn=0 and coreHalt=1.
- R4: When waitReq is sampled high while bit 2 or bit 5 is clear, the core is halted (coreHalt=1) but coreClkEn and hfOscEn stay 1.
- R5: During Idle, hfOscEn equals the inverse of bit 1 as it stood when Idle was entered.
- R6: A high level on wakeMaskable sets wakePending at the third rising clock edge after the input rises, and not before.
- R7: wakeNmiN sets wakePending only on a high-to-low transition. The same three-edge latency applies. A level that stays low sets nothing more after an acknowledge.
- R8: A falling edge on wakeDbgN is a wake source only while devMode=1.
- R9: wakePending stays set until a cycle with intAck=1, or until reset.
- R10: While in Idle, a pending wake returns the block to Active (oscillator kept running) on the next edge and clears bit 2. Bits 1 and 5 are kept.
- R11: A wake from Idle with the oscillator stopped first sets hfOscEn=1 while keeping coreClkEn=0 and coreHalt=1. The clock is ungated and the halt released on the edge after hfStable is sampled high.
- R12: A halt entered through R4 ends, with coreHalt=0, on the edge after wakePending is seen.
- R13: A waitReq sampled while wakePending=1 has no effect: the block stays Active with coreHalt=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on low-frequency clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Control register write strobe |
| regWrData | input | 8 | Control register write data |
| regRdData | output | 8 | Control register read data |
| waitReq | input | 1 | WAIT request from the CPU core |
| intAck | input | 1 | Interrupt-acknowledge cycle indicator |
| wakeMaskable | input | 1 | Maskable wake event, active high (asynchronous) |
| wakeNmiN | input | 1 | Non-maskable interrupt, falling edge (asynchronous) |
| wakeDbgN | input | 1 | Debug interrupt, falling edge (asynchronous) |
| devMode | input | 1 | Development mode, qualifies the debug interrupt |
| hfStable | input | 1 | High-frequency oscillator reports stable |
| wakePending | output | 1 | Latched wake event |
| coreClkEn | output | 1 | Core clock gate enable |
| hfOscEn | output | 1 | High-frequency oscillator enable |
| coreHalt | output | 1 | Holds the core halted |

## Verification
The bound checker watches, on every cycle, the invariants that involve only outputs. The core clock is never gated while the core is free to run. The oscillator is never off while the core clock is enabled. The clock only resumes with the oscillator already running and the idle request already cleared. A pending wake never disappears without an acknowledge, and the reserved register bits always read zero. Behaviour that depends on the input history can only be shown by the bench's scenarios. This covers synchronizer latency, edge versus level detection, gating of the debug source by devMode, the choice between Idle and a plain halt, and the wait for hfStable.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
  localparam int REG_W      = 8;
  localparam int DHF_BIT    = 1;
  localparam int IDLE_BIT   = 2;
  localparam int ENIDLE_BIT = 5;

  typedef enum logic [1:0] {
    PM_ACTIVE,
    PM_HALT,
    PM_IDLE,
    PM_OSC_WAIT
  } pmState_t;

  typedef struct packed {
    logic clrIdle;
    logic captureDhf;
  } pmcStrobe_t;
endpackage

// File: rtl/pmc_sync.sv
module pmc_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain <= {STAGES{RST_VAL}};
    else       chain <= {chain[STAGES-2:0], din};
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/pmc_datapath.sv
module pmc_datapath
  import pmc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWrEn,
  input  logic [REG_W-1:0] regWrData,
  output logic [REG_W-1:0] regRdData,
  input  logic             wakeMaskable,
  input  logic             wakeNmiN,
  input  logic             wakeDbgN,
  input  logic             devMode,
  input  logic             intAck,
  input  pmcStrobe_t       strobe,
  output logic             wakePending,
  output logic             idleReq,
  output logic             enIdle,
  output logic             hfOffLatched
);
  localparam int         NUM_SRC  = 3;
  localparam logic [2:0] SYNC_RST = 3'b110;

  logic [NUM_SRC-1:0] rawSrc;
  logic [NUM_SRC-1:0] syncSrc;
  logic               prevNmi, prevDbg;
  logic               nmiFall, dbgFall, wakeEvent;
  logic               dhfBit;

  assign rawSrc = {wakeDbgN, wakeNmiN, wakeMaskable};

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_sync
    pmc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST[i])) i_sync (
      .clk (clk),
      .rstN(rstN),
      .din (rawSrc[i]),
      .dout(syncSrc[i])
    );
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevNmi <= 1'b1;
      prevDbg <= 1'b1;
    end else begin
      prevNmi <= syncSrc[1];
      prevDbg <= syncSrc[2];
    end
  end

  assign nmiFall   = prevNmi & ~syncSrc[1];
  assign dbgFall   = prevDbg & ~syncSrc[2] & devMode;
  assign wakeEvent = syncSrc[0] | nmiFall | dbgFall;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          wakePending <= 1'b0;
    else if (wakeEvent) wakePending <= 1'b1;
    else if (intAck)    wakePending <= 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dhfBit  <= 1'b0;
      idleReq <= 1'b0;
      enIdle  <= 1'b0;
    end else begin
      if (regWrEn) begin
        dhfBit <= regWrData[DHF_BIT];
        enIdle <= regWrData[ENIDLE_BIT];
      end
      if (strobe.clrIdle)  idleReq <= 1'b0;
      else if (regWrEn)    idleReq <= regWrData[IDLE_BIT];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 hfOffLatched <= 1'b0;
    else if (strobe.captureDhf) hfOffLatched <= dhfBit;
  end

  always_comb begin
    regRdData             = '0;
    regRdData[DHF_BIT]    = dhfBit;
    regRdData[IDLE_BIT]   = idleReq;
    regRdData[ENIDLE_BIT] = enIdle;
  end
endmodule

// File: rtl/pmc_ctrl.sv
module pmc_ctrl
  import pmc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       waitReq,
  input  logic       hfStable,
  input  logic       wakePending,
  input  logic       idleReq,
  input  logic       enIdle,
  input  logic       hfOffLatched,
  output pmcStrobe_t strobe,
  output logic       coreClkEn,
  output logic       hfOscEn,
  output logic       coreHalt
);
  pmState_t state, nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= PM_ACTIVE;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    strobe    = '0;
    unique case (state)
      PM_ACTIVE: begin
        if (waitReq && !wakePending) begin
          if (idleReq && enIdle) begin
            nextState         = PM_IDLE;
            strobe.captureDhf = 1'b1;
          end else begin
            nextState = PM_HALT;
          end
        end
      end
      PM_HALT: begin
        if (wakePending) nextState = PM_ACTIVE;
      end
      PM_IDLE: begin
        if (wakePending) begin
          strobe.clrIdle = 1'b1;
          nextState      = hfOffLatched ? PM_OSC_WAIT : PM_ACTIVE;
        end
      end
      PM_OSC_WAIT: begin
        if (hfStable) nextState = PM_ACTIVE;
      end
      default: nextState = PM_ACTIVE;
    endcase
  end

  assign coreClkEn = (state == PM_ACTIVE) || (state == PM_HALT);
  assign hfOscEn   = !((state == PM_IDLE) && hfOffLatched);
  assign coreHalt  = (state != PM_ACTIVE);
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pmc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWrEn,
  input  logic [REG_W-1:0] regWrData,
  output logic [REG_W-1:0] regRdData,
  input  logic             waitReq,
  input  logic             intAck,
  input  logic             wakeMaskable,
  input  logic             wakeNmiN,
  input  logic             wakeDbgN,
  input  logic             devMode,
  input  logic             hfStable,
  output logic             wakePending,
  output logic             coreClkEn,
  output logic             hfOscEn,
  output logic             coreHalt
);
  pmcStrobe_t strobe;
  logic       idleReq, enIdle, hfOffLatched;

  pmc_datapath #(.SYNC_STAGES(SYNC_STAGES)) i_datapath (
    .clk         (clk),
    .rstN        (rstN),
    .regWrEn     (regWrEn),
    .regWrData   (regWrData),
    .regRdData   (regRdData),
    .wakeMaskable(wakeMaskable),
    .wakeNmiN    (wakeNmiN),
    .wakeDbgN    (wakeDbgN),
    .devMode     (devMode),
    .intAck      (intAck),
    .strobe      (strobe),
    .wakePending (wakePending),
    .idleReq     (idleReq),
    .enIdle      (enIdle),
    .hfOffLatched(hfOffLatched)
  );

  pmc_ctrl i_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .waitReq     (waitReq),
    .hfStable    (hfStable),
    .wakePending (wakePending),
    .idleReq     (idleReq),
    .enIdle      (enIdle),
    .hfOffLatched(hfOffLatched),
    .strobe      (strobe),
    .coreClkEn   (coreClkEn),
    .hfOscEn     (hfOscEn),
    .coreHalt    (coreHalt)
  );
endmodule

// File: rtl/pmc_checker.sv
module pmc_checker (
  input logic       clk,
  input logic       rstN,
  input logic [7:0] regRdData,
  input logic       intAck,
  input logic       wakePending,
  input logic       coreClkEn,
  input logic       hfOscEn,
  input logic       coreHalt
);
  assert_gated_halted_R3: assert property (@(posedge clk) disable iff (!rstN)
    !coreClkEn |-> coreHalt);

  assert_osc_before_clk_R11: assert property (@(posedge clk) disable iff (!rstN)
    !hfOscEn |-> !coreClkEn);

  assert_resume_osc_R11: assert property (@(posedge clk) disable iff (!rstN)
    $rose(coreClkEn) |-> (hfOscEn && $past(hfOscEn)));

  assert_resume_clears_idle_R10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(coreClkEn) |-> !regRdData[2]);

  assert_wake_held_R9: assert property (@(posedge clk) disable iff (!rstN)
    (wakePending && !intAck) |=> wakePending);

  assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rstN)
    (regRdData & 8'hD9) == 8'h00);
endmodule

bind pwr_mode_ctrl pmc_checker i_pmc_checker (
  .clk        (clk),
  .rstN       (rstN),
  .regRdData  (regRdData),
  .intAck     (intAck),
  .wakePending(wakePending),
  .coreClkEn  (coreClkEn),
  .hfOscEn    (hfOscEn),
  .coreHalt   (coreHalt)
);

// File: tb/test_pwr_mode_ctrl.sv
module test_pwr_mode_ctrl;
  logic       clk = 1'b0;
  logic       rstN;
  logic       regWrEn;
  logic [7:0] regWrData;
  logic [7:0] regRdData;
  logic       waitReq, intAck, wakeMaskable, wakeNmiN, wakeDbgN, devMode, hfStable;
  logic       wakePending, coreClkEn, hfOscEn, coreHalt;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  pwr_mode_ctrl i_pwr_mode_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(regRdData), .waitReq(waitReq), .intAck(intAck),
    .wakeMaskable(wakeMaskable), .wakeNmiN(wakeNmiN), .wakeDbgN(wakeDbgN),
    .devMode(devMode), .hfStable(hfStable), .wakePending(wakePending),
    .coreClkEn(coreClkEn), .hfOscEn(hfOscEn), .coreHalt(coreHalt)
  );

  localparam int NVEC = 6;
  localparam logic [7:0] WR_VEC [NVEC] = '{8'hFF, 8'h02, 8'h04, 8'h20, 8'hD9, 8'h00};

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic wr(input logic [7:0] v);
    regWrData = v; regWrEn = 1'b1; tick(1); regWrEn = 1'b0;
  endtask

  task automatic pulseWait();
    waitReq = 1'b1; tick(1); waitReq = 1'b0;
  endtask

  task automatic ack();
    intAck = 1'b1; tick(1); intAck = 1'b0;
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; regWrEn = 1'b0; regWrData = '0; waitReq = 1'b0; intAck = 1'b0;
    wakeMaskable = 1'b0; wakeNmiN = 1'b1; wakeDbgN = 1'b1; devMode = 1'b0; hfStable = 1'b1;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 clk", coreClkEn, 1);
    chk("R1 osc", hfOscEn, 1);
    chk("R1 halt", coreHalt, 0);
    chk("R1 reg", regRdData, 0);
    chk("R1 pend", wakePending, 0);

    // R2 register vector table
    for (int v = 0; v < NVEC; v++) begin
      wr(WR_VEC[v]);
      chk("R2 reg", regRdData, WR_VEC[v] & 8'h26);
    end

    // R4 halt with idle enable clear
    wr(8'h04);
    pulseWait();
    chk("R4 halt", coreHalt, 1);
    chk("R4 clk", coreClkEn, 1);
    chk("R4 osc", hfOscEn, 1);
    // R12 NMI ends the halt; R7 latency
    wakeNmiN = 1'b0;
    tick(2);
    chk("R7 early", wakePending, 0);
    tick(1);
    chk("R7 pend", wakePending, 1);
    chk("R12 still", coreHalt, 1);
    tick(1);
    chk("R12 exit", coreHalt, 0);
    // R9 held without ack
    tick(4);
    chk("R9 hold", wakePending, 1);
    // R13 wait while pending ignored
    pulseWait();
    chk("R13 halt", coreHalt, 0);
    ack();
    chk("R9 ack", wakePending, 0);
    tick(4);
    chk("R7 level", wakePending, 0);
    wakeNmiN = 1'b1;
    tick(4);
    chk("R7 rise", wakePending, 0);

    // R8 debug ignored without devMode
    wakeDbgN = 1'b0; tick(5);
    chk("R8 off", wakePending, 0);
    wakeDbgN = 1'b1; tick(3);
    devMode = 1'b1;
    wakeDbgN = 1'b0; tick(3);
    chk("R8 on", wakePending, 1);
    wakeDbgN = 1'b1; devMode = 1'b0;
    ack();
    chk("R9 ack2", wakePending, 0);

    // R3/R5/R10 idle with oscillator running
    wr(8'h24);
    pulseWait();
    chk("R3 clk", coreClkEn, 0);
    chk("R3 halt", coreHalt, 1);
    chk("R5 osc", hfOscEn, 1);
    wakeMaskable = 1'b1;
    tick(2);
    chk("R6 early", wakePending, 0);
    tick(1);
    chk("R6 pend", wakePending, 1);
    chk("R10 still", coreClkEn, 0);
    tick(1);
    chk("R10 clk", coreClkEn, 1);
    chk("R10 halt", coreHalt, 0);
    chk("R10 reg", regRdData, 8'h20);
    wakeMaskable = 1'b0;
    tick(3);
    ack();
    chk("R9 ack3", wakePending, 0);

    // R5/R11 idle with oscillator stopped
    wr(8'h26);
    pulseWait();
    chk("R5 off", hfOscEn, 0);
    chk("R3 clk2", coreClkEn, 0);
    hfStable = 1'b0;
    wakeNmiN = 1'b0;
    tick(4);
    chk("R11 osc", hfOscEn, 1);
    chk("R11 clk", coreClkEn, 0);
    chk("R11 halt", coreHalt, 1);
    chk("R10 clr", regRdData, 8'h22);
    tick(3);
    chk("R11 wait", coreClkEn, 0);
    hfStable = 1'b1;
    tick(1);
    chk("R11 clk on", coreClkEn, 1);
    chk("R11 halt off", coreHalt, 0);
    wakeNmiN = 1'b1;
    ack();

    // R3 only idle-enable set is a plain halt (R4)
    wr(8'h20);
    pulseWait();
    chk("R4 clk2", coreClkEn, 1);
    chk("R4 halt2", coreHalt, 1);

    // R1 reset clears pending and returns to Active
    wakeMaskable = 1'b1; tick(3);
    wakeMaskable = 1'b0;
    rstN = 1'b0; tick(1); rstN = 1'b1; tick(1);
    chk("R1 rst pend", wakePending, 0);
    chk("R1 rst halt", coreHalt, 0);
    chk("R1 rst reg", regRdData, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule